// File: doc/BRIEF.md
# Open-Drain I/O Latch Bank with Supply-Gated Recall

This block drives four open-drain pins from a small byte-addressed register map. Each pin has an output latch that pulls it low, a selectable pullup, and an input path that is brought into the clock domain through a two-flop synchroniser. A status register returns the synchronised pin levels. The pin electrics are modelled as two vectors: one drive-low enable and one pullup enable for each pin.

Every latch and pullup bit is held twice. A volatile working copy feeds the pins. A persistent copy survives supply loss and is cleared only by `rst_ni`. Every accepted write updates both copies. Two digital supply indications form a hysteresis window. The bank stays released until the upper indication `sv_rise_i` is seen. It then spends `RECALL_CYCLES` clocks copying the persistent values into the working copy before it drives the pins. After that it holds its state until the lower indication `sv_fall_i` drops.

Top module: `io_latch_bank`

## Requirements
- R1: While `rst_ni` is low and immediately after it is released, `pin_oe_o` and `pin_pu_o` are all zero and `bus_rvalid_o` is low.
- R2: The pins stay released (`pin_oe_o` and `pin_pu_o` zero) until `sv_rise_i` and `sv_fall_i` are both seen high. After that the recall runs for `RECALL_CYCLES` clocks, during which the pins remain released.
- R3: Address 0xF0 holds the pullup enables, with bit n driving `pin_pu_o[n]`. It reads back as `{4'b0, enables}`.
- R4: Address 0xF4+n is the control register of pin n. Only bit 0 is used: 1 drives the pin low (`pin_oe_o[n]`=1) and 0 releases it. Other bits are ignored, and the register reads back as `{7'b0, bit0}`.
- R5: Address 0xF8 reads `{4'b0, pin levels}`, where the levels are sampled from `pin_i` through a two-flop synchroniser. Writes to it have no effect.
- R6: A read strobe `bus_re_i` produces `bus_rvalid_o` with data on the next cycle, and no valid appears without a strobe. Unmapped addresses read 0x00, and writes to them change no state.
- R7: Once the bank is active, its state holds while `sv_fall_i` is high, even if `sv_rise_i` falls. When `sv_fall_i` goes low, every pin is released on the next cycle.
- R8: After supply loss and a new recall, the pins and registers return to the last values written while the bank was active.
- R9: While the bank is not active (off or recalling), writes are discarded from both copies and reads return 0x00.
- R10: If `sv_fall_i` drops during the recall, the recall aborts, and a new recall needs `sv_rise_i` high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset; clears the persistent copy too |
| sv_rise_i | input | 1 | Supply above the power-up threshold |
| sv_fall_i | input | 1 | Supply above the lower hold threshold |
| bus_we_i | input | 1 | Register write strobe |
| bus_re_i | input | 1 | Register read strobe |
| bus_addr_i | input | 8 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid with `bus_rvalid_o` |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after the strobe |
| pin_i | input | 4 | Sensed pin levels (asynchronous) |
| pin_oe_o | output | 4 | Per-pin drive-low enable |
| pin_pu_o | output | 4 | Per-pin pullup enable |

## Verification
The assertions check on every cycle the read handshake timing, the zero data returned for unmapped addresses and while the bank is inactive, the zero upper bits of every read, and the release of all pins one cycle after the lower supply indication drops. The scenarios alone show the end-to-end behaviour:
- writes are discarded while the bank is off;
- the pins stay released through the recall window;
- state holds when only the upper indication falls;
- a recall aborted midway does not resume without a fresh rise;
- the last written values reappear after a full supply cycle.

// File: rtl/io_bank_pkg.sv
package io_bank_pkg;
  localparam int unsigned ADDR_W    = 8;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned PU_ADDR   = 'hF0;
  localparam int unsigned CTRL_BASE = 'hF4;
  localparam int unsigned STAT_ADDR = 'hF8;

  typedef enum logic [1:0] {
    SUP_OFF    = 2'd0,
    SUP_RECALL = 2'd1,
    SUP_ON     = 2'd2
  } sup_state_e;
endpackage

// File: rtl/io_supply_ctrl.sv
module io_supply_ctrl
  import io_bank_pkg::*;
#(
  parameter int unsigned RECALL_CYCLES = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sv_rise_i,
  input  logic       sv_fall_i,
  output logic       ready_o,
  output logic       recall_ld_o,
  output logic       wipe_o,
  output sup_state_e state_o
);
  localparam int unsigned CNT_W = $clog2(RECALL_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RECALL_CYCLES - 1);

  sup_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    recall_ld_o = 1'b0;
    unique case (state_q)
      SUP_OFF: begin
        cnt_d = '0;
        if (sv_rise_i && sv_fall_i) state_d = SUP_RECALL;
      end
      SUP_RECALL: begin
        if (!sv_fall_i) begin
          state_d = SUP_OFF;
        end else if (cnt_q == CNT_LAST) begin
          state_d     = SUP_ON;
          recall_ld_o = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      SUP_ON: begin
        if (!sv_fall_i) state_d = SUP_OFF;
      end
      default: state_d = SUP_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SUP_OFF;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign ready_o = (state_q == SUP_ON);
  assign wipe_o  = (state_q == SUP_OFF);
  assign state_o = state_q;
endmodule

// File: rtl/io_pin_sync.sv
module io_pin_sync #(
  parameter int unsigned N_PINS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] pin_i,
  output logic [N_PINS-1:0] pin_sync_o
);
  for (genvar g = 0; g < N_PINS; g++) begin : g_sync
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= pin_i[g];
        s2_q <= s1_q;
      end
    end
    assign pin_sync_o[g] = s2_q;
  end
endmodule

// File: rtl/io_reg_file.sv
module io_reg_file
  import io_bank_pkg::*;
#(
  parameter int unsigned N_PINS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ready_i,
  input  logic              recall_ld_i,
  input  logic              wipe_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [N_PINS-1:0] pin_sync_i,
  output logic [N_PINS-1:0] latch_o,
  output logic [N_PINS-1:0] pu_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  localparam logic [ADDR_W-1:0] A_PU   = ADDR_W'(PU_ADDR);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);

  logic              wr_ok;
  logic [N_PINS-1:0] pu_sh_q, pu_nv_q;
  logic [N_PINS-1:0] lat_sh, lat_nv;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;

  assign wr_ok = we_i && ready_i;

  // pullup register: volatile working copy and persistent copy
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pu_sh_q <= '0;
      pu_nv_q <= '0;
    end else begin
      if (wipe_i)                             pu_sh_q <= '0;
      else if (recall_ld_i)                   pu_sh_q <= pu_nv_q;
      else if (wr_ok && addr_i == A_PU)       pu_sh_q <= wdata_i[N_PINS-1:0];
      if (wr_ok && addr_i == A_PU)            pu_nv_q <= wdata_i[N_PINS-1:0];
    end
  end

  for (genvar g = 0; g < N_PINS; g++) begin : g_lat
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_BASE + g);
    logic sh_q, nv_q, hit;
    assign hit = wr_ok && (addr_i == A_CTRL);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sh_q <= 1'b0;
        nv_q <= 1'b0;
      end else begin
        if (wipe_i)           sh_q <= 1'b0;
        else if (recall_ld_i) sh_q <= nv_q;
        else if (hit)         sh_q <= wdata_i[0];
        if (hit)              nv_q <= wdata_i[0];
      end
    end
    assign lat_sh[g] = sh_q;
    assign lat_nv[g] = nv_q;
  end

  always_comb begin
    rd_mux = '0;
    if (addr_i == A_PU)   rd_mux[N_PINS-1:0] = pu_sh_q;
    if (addr_i == A_STAT) rd_mux[N_PINS-1:0] = pin_sync_i;
    for (int n = 0; n < N_PINS; n++) begin
      if (addr_i == ADDR_W'(CTRL_BASE + n)) rd_mux[0] = lat_sh[n];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= re_i;
      rdata_q  <= (re_i && ready_i) ? rd_mux : '0;
    end
  end

  logic unused_nv;
  assign unused_nv = ^lat_nv;

  assign latch_o  = lat_sh;
  assign pu_o     = pu_sh_q;
  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
endmodule

// File: rtl/io_latch_bank.sv
module io_latch_bank
  import io_bank_pkg::*;
#(
  parameter int unsigned N_PINS        = 4,
  parameter int unsigned RECALL_CYCLES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sv_rise_i,
  input  logic              sv_fall_i,
  input  logic              bus_we_i,
  input  logic              bus_re_i,
  input  logic [7:0]        bus_addr_i,
  input  logic [7:0]        bus_wdata_i,
  output logic [7:0]        bus_rdata_o,
  output logic              bus_rvalid_o,
  input  logic [N_PINS-1:0] pin_i,
  output logic [N_PINS-1:0] pin_oe_o,
  output logic [N_PINS-1:0] pin_pu_o
);
  logic              ready, recall_ld, wipe;
  sup_state_e        sup_state;
  logic [N_PINS-1:0] pin_sync, latch, pu;

  io_supply_ctrl #(.RECALL_CYCLES(RECALL_CYCLES)) u_sup (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sv_rise_i  (sv_rise_i),
    .sv_fall_i  (sv_fall_i),
    .ready_o    (ready),
    .recall_ld_o(recall_ld),
    .wipe_o     (wipe),
    .state_o    (sup_state)
  );

  io_pin_sync #(.N_PINS(N_PINS)) u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pin_i     (pin_i),
    .pin_sync_o(pin_sync)
  );

  io_reg_file #(.N_PINS(N_PINS)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ready_i    (ready),
    .recall_ld_i(recall_ld),
    .wipe_i     (wipe),
    .we_i       (bus_we_i),
    .re_i       (bus_re_i),
    .addr_i     (bus_addr_i),
    .wdata_i    (bus_wdata_i),
    .pin_sync_i (pin_sync),
    .latch_o    (latch),
    .pu_o       (pu),
    .rdata_o    (bus_rdata_o),
    .rvalid_o   (bus_rvalid_o)
  );

  // pins released until recall completes
  assign pin_oe_o = ready ? latch : '0;
  assign pin_pu_o = ready ? pu    : '0;

  logic unused_state;
  assign unused_state = ^sup_state;
endmodule

// File: rtl/io_latch_bank_chk.sv
module io_latch_bank_chk
  import io_bank_pkg::*;
#(
  parameter int unsigned N_PINS = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sv_fall_i,
  input logic              bus_re_i,
  input logic [7:0]        bus_addr_i,
  input logic [7:0]        bus_rdata_o,
  input logic              bus_rvalid_o,
  input logic [N_PINS-1:0] pin_oe_o,
  input logic [N_PINS-1:0] pin_pu_o,
  input logic              ready
);
  logic mapped;
  always_comb begin
    mapped = (int'(bus_addr_i) == PU_ADDR) || (int'(bus_addr_i) == STAT_ADDR) ||
             ((int'(bus_addr_i) >= CTRL_BASE) && (int'(bus_addr_i) < CTRL_BASE + N_PINS));
  end

  a_r7_release_on_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sv_fall_i |=> (pin_oe_o == '0 && pin_pu_o == '0));

  a_r6_rvalid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_re_i |=> bus_rvalid_o);

  a_r6_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_re_i |=> !bus_rvalid_o);

  a_r6_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_re_i && !mapped) |=> bus_rdata_o == '0);

  a_r9_idle_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_re_i && !ready) |=> bus_rdata_o == '0);

  a_r3_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rvalid_o |-> (bus_rdata_o >> N_PINS) == '0);
endmodule

bind io_latch_bank io_latch_bank_chk #(.N_PINS(N_PINS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sv_fall_i   (sv_fall_i),
  .bus_re_i    (bus_re_i),
  .bus_addr_i  (bus_addr_i),
  .bus_rdata_o (bus_rdata_o),
  .bus_rvalid_o(bus_rvalid_o),
  .pin_oe_o    (pin_oe_o),
  .pin_pu_o    (pin_pu_o),
  .ready       (ready)
);

// File: tb/io_latch_bank_test.sv
`timescale 1ns/1ps
module io_latch_bank_test;
  localparam int RC = 16;
  localparam real TCK = 5.0;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sv_rise = 1'b0, sv_fall = 1'b0;
  logic       we = 1'b0, re = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rdata;
  logic       rvalid;
  logic [3:0] pin_in = '0, oe, pu;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(TCK/2) clk = ~clk;

  io_latch_bank #(.N_PINS(4), .RECALL_CYCLES(RC)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .sv_rise_i(sv_rise), .sv_fall_i(sv_fall),
    .bus_we_i(we), .bus_re_i(re), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .bus_rvalid_o(rvalid),
    .pin_i(pin_in), .pin_oe_o(oe), .pin_pu_o(pu)
  );

  task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    re = 1'b1; addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    re = 1'b0;
  endtask

  // monitor: compare read results against scoreboard
  always @(negedge clk) begin
    if (rst_ni && rvalid) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R6 unexpected rvalid got=%h exp=none", rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rdata, e, t);
      end
    end
  end

  task automatic pins(input logic [3:0] e_oe, input logic [3:0] e_pu, input string tag);
    chk({4'b0, oe}, {4'b0, e_oe}, {tag, " oe"});
    chk({4'b0, pu}, {4'b0, e_pu}, {tag, " pu"});
  endtask

  initial begin
    cyc(3);
    pins(4'h0, 4'h0, "R1 in reset");
    chk({7'b0, rvalid}, 8'h00, "R1 rvalid in reset");
    rst_ni = 1'b1;
    cyc(2);
    pins(4'h0, 4'h0, "R1 after reset");

    // off: reads zero, writes discarded
    rd(8'hF0, 8'h00, "R9 read while off");
    wr(8'hF0, 8'h0F);
    wr(8'hF5, 8'h01);
    pins(4'h0, 4'h0, "R2 off no drive");

    // only lower indication: stays off
    sv_fall = 1'b1;
    cyc(RC + 5);
    pins(4'h0, 4'h0, "R2 no rise yet");

    sv_rise = 1'b1;
    cyc(5);
    pins(4'h0, 4'h0, "R2 during recall");
    rd(8'hF0, 8'h00, "R9 read during recall");
    cyc(RC + 2);
    rd(8'hF0, 8'h00, "R9 off-time pullup write discarded");
    rd(8'hF5, 8'h00, "R9 off-time control write discarded");

    wr(8'hF0, 8'hF5);
    pins(4'h0, 4'h5, "R3 pullup write");
    rd(8'hF0, 8'h05, "R3 pullup readback");

    wr(8'hF4, 8'hFF);
    pins(4'h1, 4'h5, "R4 pin0 drive");
    wr(8'hF6, 8'h01);
    pins(4'h5, 4'h5, "R4 pin2 drive");
    wr(8'hF4, 8'hFE);
    pins(4'h4, 4'h5, "R4 bit0 zero releases");
    rd(8'hF4, 8'h00, "R4 readback pin0");
    rd(8'hF6, 8'h01, "R4 readback pin2");
    wr(8'hF7, 8'h03);
    pins(4'hC, 4'h5, "R4 pin3 drive");
    wr(8'hF7, 8'h00);
    pins(4'h4, 4'h5, "R4 pin3 release");

    wr(8'hF9, 8'hFF);
    wr(8'hF3, 8'hFF);
    wr(8'hF8, 8'hFF);
    pins(4'h4, 4'h5, "R6 unmapped write no effect");
    rd(8'hF9, 8'h00, "R6 unmapped read F9");
    rd(8'hF3, 8'h00, "R6 unmapped read F3");
    rd(8'hF0, 8'h05, "R6 pullup intact");

    pin_in = 4'hA;
    cyc(3);
    rd(8'hF8, 8'h0A, "R5 status A");
    pin_in = 4'h3;
    cyc(3);
    rd(8'hF8, 8'h03, "R5 status 3");

    // upper indication falls, lower holds
    sv_rise = 1'b0;
    cyc(10);
    pins(4'h4, 4'h5, "R7 hold on rise low");
    rd(8'hF6, 8'h01, "R7 register hold");

    @(negedge clk);
    sv_fall = 1'b0;
    @(negedge clk);
    pins(4'h0, 4'h0, "R7 release after drop");
    rd(8'hF0, 8'h00, "R9 read after drop");

    sv_fall = 1'b1;
    cyc(RC + 5);
    pins(4'h0, 4'h0, "R2 fall only no recall");
    sv_rise = 1'b1;
    cyc(RC + 4);
    pins(4'h4, 4'h5, "R8 recalled pins");
    rd(8'hF6, 8'h01, "R8 recalled ctrl");
    rd(8'hF0, 8'h05, "R8 recalled pullup");

    // aborted recall
    sv_fall = 1'b0; sv_rise = 1'b0;
    cyc(3);
    sv_fall = 1'b1; sv_rise = 1'b1;
    cyc(RC / 2);
    sv_fall = 1'b0; sv_rise = 1'b0;
    cyc(2);
    sv_fall = 1'b1;
    cyc(RC + 8);
    pins(4'h0, 4'h0, "R10 abort stays off");
    sv_rise = 1'b1;
    cyc(RC + 4);
    pins(4'h4, 4'h5, "R10 recall after new rise");

    cyc(3);
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL R6 missing rvalid got=%0d exp=0 pending", exp_q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(TCK * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule